// File: doc/BRIEF.md
# CRC-32C Segment Merge Unit

This unit joins two CRC-32C register values taken over neighbouring pieces of a data stream into the register value for the whole stream, without reading the data again. The caller provides the register value reached at the end of the earlier piece, the register value of the later piece computed from an all-zero start, and the byte length N of the later piece. The unit advances the earlier value across N zero bytes by multiplying it with x^(8N) modulo the CRC-32C generator. It then XORs in the later value.

The power x^(8N) is built by square-and-multiply over the bits of N. Each GF(2) product is formed by a bit-serial multiplier that handles one operand bit per clock. Every value uses reflected bit order: bit 31 holds the x^0 coefficient, and the generator without its x^32 term is 0x82F63B78. Input and output are raw register contents. The pre-inversion of the leading lane and the final inversion belong to the caller. Three or more lanes are merged by feeding the result back in as the earlier value, together with the next lane.

Top module: `crc32c_lane_merge`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `mergedCrc` is 0.
- R2: For any byte string S1 and any start value I, let `firstCrc` be the raw reflected register after S1 from I, and let `secondCrc` be the raw register after S2 from 0, where S2 has length `segLen`. Then `mergedCrc` equals the raw register after S1 followed by S2 from I. The register is updated per byte with crc ^= byte, then 8 steps of crc = crc[0] ? (crc>>1)^0x82F63B78 : crc>>1.
- R3: With I = 0xFFFFFFFF, S1 = ASCII "12345" and S2 = ASCII "6789", the bitwise inverse of `mergedCrc` is 0xE3069283.
- R4: When `segLen` is 0, `mergedCrc` is `firstCrc` XOR `secondCrc`, and `done` rises no more than 3 clock edges after the edge that accepts `start`.
- R5: A `start` pulse while `busy` is 1 is ignored. The running merge finishes with the result for its own inputs, and no extra `done` follows.
- R6: `done` is a single-cycle pulse. `busy` stays 1 from the cycle after acceptance until the `done` cycle and is 0 in the cycle after `done`.
- R7: Each GF(2) multiply finishes in at most 32 cycles, and its scanned operand is never zero.
- R8: While `busy` is 0, `mergedCrc` holds its last value, whatever the data inputs do.
- R9: The largest length, `segLen` = 2^LEN_W − 1, gives the correct merged value.
- R10: Three lanes merged in two passes, with the first result used as `firstCrc` of the second pass, give the raw register of the three pieces joined together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a merge; sampled only while idle |
| firstCrc | input | 32 | Register value after the earlier piece |
| secondCrc | input | 32 | Register value of the later piece from a zero start |
| segLen | input | LEN_W | Byte length of the later piece |
| busy | output | 1 | A merge is in progress |
| done | output | 1 | One-cycle pulse; `mergedCrc` is valid |
| mergedCrc | output | 32 | Merged register value, held until the next merge |

## Verification
Several properties are checked in every cycle: the one-cycle `done` pulse and the `busy` window around it, the 32-cycle limit and nonzero scanned operand of each multiply, the stability of `mergedCrc` while idle, and the locking of the latched inputs during a merge. Whether the merged value is arithmetically right shows only in the bench scenarios. The bench compares the result with a byte-by-byte register model run over the concatenated data, over random pieces, the zero and maximum lengths, a three-lane chain and the standard check string. The bench also covers the ignored mid-run start by checking both the result and the absence of a second `done`.

// File: rtl/crc_merge_pkg.sv
package crc_merge_pkg;

  localparam int unsigned CRC_W = 32;
  // reflected generator, x^32 term dropped
  localparam logic [CRC_W-1:0] REFL_POLY = 32'h82F6_3B78;
  // reflected x^0 and x^4
  localparam logic [CRC_W-1:0] X_POW0 = 32'h8000_0000;
  localparam logic [CRC_W-1:0] X_POW4 = 32'h0800_0000;

  typedef enum logic [1:0] {
    OPS_SQUARE,
    OPS_ACCUM,
    OPS_APPLY
  } mulSel_e;

  typedef struct packed {
    logic    load;
    logic    multGo;
    mulSel_e sel;
    logic    takeSq;
    logic    takeOp;
    logic    takeOut;
    logic    passOut;
    logic    shiftLen;
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SQ_GO,
    ST_SQ_WAIT,
    ST_AC_GO,
    ST_AC_WAIT,
    ST_NEXT,
    ST_AP_GO,
    ST_AP_WAIT,
    ST_FIN
  } mergeState_e;

endpackage

// File: rtl/crc_gf_mult.sv
module crc_gf_mult #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'h82F6_3B78
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic         done,
  output logic [W-1:0] prod
);

  localparam int unsigned CNT_W = $clog2(W) + 1;

  logic [W-1:0]     aReg, bReg, accReg;
  logic             running, doneReg;
  logic [CNT_W-1:0] stepCnt;
  logic [W-1:0]     accNext, aShift;

  function automatic logic [W-1:0] timesX(input logic [W-1:0] v);
    return v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
  endfunction

  always_comb begin
    accNext = aReg[W-1] ? (accReg ^ bReg) : accReg;
    aShift  = {aReg[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      accReg  <= '0;
      running <= 1'b0;
      doneReg <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneReg <= 1'b0;
      if (go) begin
        aReg    <= aIn;
        bReg    <= bIn;
        accReg  <= '0;
        running <= 1'b1;
        stepCnt <= '0;
      end else if (running) begin
        accReg  <= accNext;
        aReg    <= aShift;
        bReg    <= timesX(bReg);
        stepCnt <= stepCnt + 1'b1;
        if (aShift == '0) begin
          running <= 1'b0;
          doneReg <= 1'b1;
        end
      end
    end
  end

  assign done = doneReg;
  assign prod = accReg;

  // R7: a multiply never runs past W steps
  assert_mult_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (stepCnt < CNT_W'(W)));

  // R7: the scanned operand is never zero, and no launch lands on a running multiply
  assert_mult_operand_R7: assert property (@(posedge clk) disable iff (!rstN)
    go |-> (aIn != '0) && !running);

endmodule

// File: rtl/merge_datapath.sv
module merge_datapath
  import crc_merge_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CRC_W-1:0] firstIn,
  input  logic [CRC_W-1:0] secondIn,
  input  logic [LEN_W-1:0] lenIn,
  output logic             lenIsZero,
  output logic             lenBit0,
  output logic             lenLast,
  output logic             multDone,
  output logic [CRC_W-1:0] crcOut
);

  logic [CRC_W-1:0] firstReg, secondReg, opReg, sqReg, outReg;
  logic [LEN_W-1:0] lenReg;
  logic [CRC_W-1:0] mulA, mulB, mulProd;

  always_comb begin
    unique case (ctl.sel)
      OPS_ACCUM: begin mulA = sqReg; mulB = opReg;    end
      OPS_APPLY: begin mulA = opReg; mulB = firstReg; end
      default:   begin mulA = sqReg; mulB = sqReg;    end
    endcase
  end

  crc_gf_mult #(.W(CRC_W), .POLY(REFL_POLY)) mult_i (
    .clk  (clk),
    .rstN (rstN),
    .go   (ctl.multGo),
    .aIn  (mulA),
    .bIn  (mulB),
    .done (multDone),
    .prod (mulProd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstReg  <= '0;
      secondReg <= '0;
      lenReg    <= '0;
      opReg     <= X_POW0;
      sqReg     <= X_POW4;
      outReg    <= '0;
    end else begin
      if (ctl.load) begin
        firstReg  <= firstIn;
        secondReg <= secondIn;
        lenReg    <= lenIn;
        opReg     <= X_POW0;
        sqReg     <= X_POW4;
      end
      if (ctl.takeSq)   sqReg  <= mulProd;
      if (ctl.takeOp)   opReg  <= mulProd;
      if (ctl.takeOut)  outReg <= mulProd ^ secondReg;
      if (ctl.passOut)  outReg <= firstReg ^ secondReg;
      if (ctl.shiftLen) lenReg <= lenReg >> 1;
    end
  end

  assign lenIsZero = (lenReg == '0);
  assign lenBit0   = lenReg[0];
  assign lenLast   = ((lenReg >> 1) == '0);
  assign crcOut    = outReg;

  // R7: the powers fed to the multiplier stay nonzero
  assert_powers_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opReg != '0) && (sqReg != '0));

endmodule

// File: rtl/merge_control.sv
module merge_control
  import crc_merge_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lenIsZero,
  input  logic   lenBit0,
  input  logic   lenLast,
  input  logic   multDone,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  mergeState_e state, stateNext;

  always_comb begin
    ctl       = '0;
    ctl.sel   = OPS_SQUARE;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (lenIsZero) begin
          ctl.passOut = 1'b1;
          stateNext   = ST_FIN;
        end else begin
          stateNext = ST_SQ_GO;
        end
      end
      ST_SQ_GO: begin
        ctl.multGo = 1'b1;
        stateNext  = ST_SQ_WAIT;
      end
      ST_SQ_WAIT: if (multDone) begin
        ctl.takeSq = 1'b1;
        stateNext  = lenBit0 ? ST_AC_GO : ST_NEXT;
      end
      ST_AC_GO: begin
        ctl.multGo = 1'b1;
        ctl.sel    = OPS_ACCUM;
        stateNext  = ST_AC_WAIT;
      end
      ST_AC_WAIT: if (multDone) begin
        ctl.takeOp = 1'b1;
        stateNext  = ST_NEXT;
      end
      ST_NEXT: begin
        ctl.shiftLen = 1'b1;
        stateNext    = lenLast ? ST_AP_GO : ST_SQ_GO;
      end
      ST_AP_GO: begin
        ctl.multGo = 1'b1;
        ctl.sel    = OPS_APPLY;
        stateNext  = ST_AP_WAIT;
      end
      ST_AP_WAIT: if (multDone) begin
        ctl.takeOut = 1'b1;
        stateNext   = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R6: done lasts exactly one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: busy cannot drop before done
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R6: the cycle after done is idle
  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/crc32c_lane_merge.sv
module crc32c_lane_merge
  import crc_merge_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      firstCrc,
  input  logic [31:0]      secondCrc,
  input  logic [LEN_W-1:0] segLen,
  output logic             busy,
  output logic             done,
  output logic [31:0]      mergedCrc
);

  dpCtl_t ctl;
  logic   lenIsZero, lenBit0, lenLast, multDone;

  merge_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lenIsZero (lenIsZero),
    .lenBit0   (lenBit0),
    .lenLast   (lenLast),
    .multDone  (multDone),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  merge_datapath #(.LEN_W(LEN_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .firstIn   (firstCrc),
    .secondIn  (secondCrc),
    .lenIn     (segLen),
    .lenIsZero (lenIsZero),
    .lenBit0   (lenBit0),
    .lenLast   (lenLast),
    .multDone  (multDone),
    .crcOut    (mergedCrc)
  );

  // R8: result register is frozen while idle
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(mergedCrc));

  // R5: latched operands cannot change during a merge
  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dp_i.secondReg) && $stable(dp_i.firstReg));

endmodule

// File: tb/crc32c_lane_merge_tb_top.sv
`timescale 1ns/1ps
module crc32c_lane_merge_tb_top;

  localparam int unsigned LEN_W = 16;
  localparam logic [31:0] GEN = 32'h82F6_3B78;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      firstCrc = '0;
  logic [31:0]      secondCrc = '0;
  logic [LEN_W-1:0] segLen = '0;
  logic             busy, done;
  logic [31:0]      mergedCrc;

  int vecCount = 0;
  int missCount = 0;
  int cycleCount = 0;
  logic [7:0] dataBuf [0:255];

  always #2.5 clk = ~clk;

  crc32c_lane_merge #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .firstCrc(firstCrc),
    .secondCrc(secondCrc), .segLen(segLen), .busy(busy), .done(done),
    .mergedCrc(mergedCrc)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount == 190000) begin
      missCount = missCount + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycleCount);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  function automatic logic [31:0] stepByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ GEN) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] rawCrc(input logic [31:0] init, input int from, input int cnt);
    logic [31:0] r = init;
    for (int i = 0; i < cnt; i++) r = stepByte(r, dataBuf[from + i]);
    return r;
  endfunction

  function automatic logic [31:0] zeroRun(input logic [31:0] init, input int cnt);
    logic [31:0] r = init;
    for (int i = 0; i < cnt; i++) r = stepByte(r, 8'h00);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic runMerge(input logic [31:0] a, input logic [31:0] b, input int len,
                          output logic [31:0] res, output int cycles);
    @(negedge clk);
    start = 1'b1; firstCrc = a; secondCrc = b; segLen = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    res = mergedCrc;
  endtask

  initial begin
    logic [31:0] res, res2, expv, initV, ca, cb, cc;
    int cyc, l1, l2, l3, extraDone;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) dataBuf[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1 flags", {30'h0, busy, done}, 32'h0);
    check(mergedCrc == 32'h0, "R1 output", mergedCrc, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 standard check string split 5 + 4
    for (int i = 0; i < 9; i++) dataBuf[200 + i] = 8'h31 + 8'(i);
    ca = rawCrc(32'hFFFF_FFFF, 200, 5);
    cb = rawCrc(32'h0, 205, 4);
    runMerge(ca, cb, 4, res, cyc);
    check(done && (~res == 32'hE306_9283), "R3 check string", ~res, 32'hE306_9283);

    // R4 zero length passes XOR through quickly
    runMerge(32'h1234_5678, 32'h0F0F_A5A5, 0, res, cyc);
    check(res == (32'h1234_5678 ^ 32'h0F0F_A5A5), "R4 value", res, 32'h1234_5678 ^ 32'h0F0F_A5A5);
    check(cyc <= 3, "R4 latency", 32'(cyc), 32'd3);

    // R6 pulse shape after that done
    @(negedge clk);
    check(!done && !busy, "R6 pulse ends", {30'h0, busy, done}, 32'h0);

    // R2 random pieces
    for (int t = 0; t < 40; t++) begin
      l1 = int'($urandom_range(0, 60));
      l2 = int'($urandom_range(1, 60));
      initV = $urandom;
      ca = rawCrc(initV, 0, l1);
      cb = rawCrc(32'h0, l1, l2);
      expv = rawCrc(initV, 0, l1 + l2);
      runMerge(ca, cb, l2, res, cyc);
      check(done && res == expv, "R2 random merge", res, expv);
    end

    // R2 length one and a power of two
    ca = 32'hDEAD_BEEF; cb = rawCrc(32'h0, 10, 1);
    expv = stepByte(ca, dataBuf[10]);
    runMerge(ca, cb, 1, res, cyc);
    check(res == expv, "R2 length one", res, expv);
    ca = 32'h0; cb = rawCrc(32'h0, 0, 128);
    runMerge(ca, cb, 128, res, cyc);
    check(res == cb, "R2 zero first lane", res, cb);

    // R9 maximum length
    ca = 32'hC001_D00D; cb = 32'h5555_AAAA;
    expv = zeroRun(ca, (1 << LEN_W) - 1) ^ cb;
    runMerge(ca, cb, (1 << LEN_W) - 1, res, cyc);
    check(done && res == expv, "R9 max length", res, expv);

    // R10 three lanes in two passes
    l1 = 17; l2 = 33; l3 = 50;
    initV = 32'hFFFF_FFFF;
    ca = rawCrc(initV, 0, l1);
    cb = rawCrc(32'h0, l1, l2);
    cc = rawCrc(32'h0, l1 + l2, l3);
    runMerge(ca, cb, l2, res, cyc);
    runMerge(res, cc, l3, res2, cyc);
    expv = rawCrc(initV, 0, l1 + l2 + l3);
    check(res2 == expv, "R10 three lanes", res2, expv);

    // R5 start during busy is ignored
    ca = rawCrc(32'h1357_9BDF, 0, 20);
    cb = rawCrc(32'h0, 20, 200);
    expv = rawCrc(32'h1357_9BDF, 0, 220);
    @(negedge clk);
    start = 1'b1; firstCrc = ca; secondCrc = cb; segLen = LEN_W'(200);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; firstCrc = 32'hFFFF_0000; secondCrc = 32'h1111_2222; segLen = LEN_W'(3);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    res = mergedCrc;
    check(res == expv, "R5 result kept", res, expv);
    extraDone = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done || busy) extraDone++;
    end
    check(extraDone == 0, "R5 no second run", 32'(extraDone), 32'h0);

    // R8 output held while idle with inputs moving
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      firstCrc = $urandom; secondCrc = $urandom; segLen = LEN_W'($urandom);
    end
    @(negedge clk);
    check(mergedCrc == res, "R8 hold", mergedCrc, res);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule